// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit register datapath and a little-endian, byte-addressed 32-bit data memory with a single-cycle synchronous read port. For each request it adds a signed 16-bit displacement to a base register to form the byte address. It drives the memory word address, the byte-lane enables and, for stores, the write data moved onto the lanes the address selects. The memory returns read data on the cycle after a load is issued. In that cycle the unit picks the addressed byte, halfword or word out of the returned word and widens it to 32 bits, filling with zeros or with copies of the sign bit.

A request is one cycle of `req_valid` with its operands. Any halfword request at an odd address, any word request at an address that is not a multiple of four, and the reserved size code are refused. A refused request raises `misalign`, drives no enables and never reaches the memory. Arbitration, caching and wait states are left to the surrounding logic.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `base` plus `disp` sign-extended to 32 bits, taken modulo 2^32, in the same cycle as the request.
- R2: `req_size` codes are 00 byte, 01 halfword, 10 word and 11 reserved. For an accepted request `mem_be` is one-hot at bit `mem_addr[1:0]` for a byte, 4'b0011 or 4'b1100 for a halfword at offset 0 or 2, and 4'b1111 for a word. `mem_be` is 0 when no request is accepted.
- R3: On an accepted store, lane `mem_addr[1:0]+k` of `mem_wdata` (bits 8*lane+7 down to 8*lane) carries bits 8k+7 down to 8k of `store_data` for each byte k of the access. For a word this puts `store_data[7:0]` at the lowest address.
- R4: A byte store enables exactly one lane. It changes only the addressed memory byte and writes only `store_data[7:0]`.
- R5: A request is misaligned when it is a halfword with `mem_addr[0]`=1, a word with `mem_addr[1:0]`≠0, or size code 11. It then raises `misalign` in the same cycle, holds `mem_we`, `mem_re` and `mem_be` at 0, and produces no load response.
- R6: `ld_valid` is high for exactly the one cycle after each accepted load and at no other time.
- R7: A word load returns the addressed memory word, with the byte at the lowest address in `ld_data[7:0]`.
- R8: A byte load with `req_unsigned`=1 places the byte in `ld_data[7:0]` and zeros in bits 31:8. A halfword load with `req_unsigned`=1 places the halfword in bits 15:0 and zeros in bits 31:16.
- R9: A byte load with `req_unsigned`=0 fills bits 31:8 with copies of the loaded byte's bit 7. A halfword load with `req_unsigned`=0 fills bits 31:16 with copies of the halfword's bit 15.
- R10: While `rst_n` is low and on the first cycle after reset, `ld_valid` is 0. With `req_valid` low, `mem_we`, `mem_re` and `mem_be` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | 1 selects zero extension on loads |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_re` |
| misalign | output | 1 | Request refused as misaligned or reserved |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench uses the default package widths: a 32-bit datapath, four lanes and a 16-bit displacement. With these widths every lane offset 0 to 3 can be reached, and so can both signs of the displacement and an address that wraps past 2^32. Byte values with bit 7 set or clear, and halfwords with bit 15 set or clear, are stored and then read back at each offset with both extension modes. A behavioural memory in the bench honours the enables, so a later word read shows whether the neighbouring bytes survived a narrow store or a refused one.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int unsigned LSU_XLEN   = 32;
  localparam int unsigned LSU_DISP_W = 16;
  localparam int unsigned LSU_LANES  = LSU_XLEN / 8;
  localparam int unsigned LSU_OFS_W  = $clog2(LSU_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } lsu_size_e;

  typedef logic [LSU_XLEN-1:0]   word_t;
  typedef logic [LSU_DISP_W-1:0] disp_t;
  typedef logic [LSU_OFS_W-1:0]  ofs_t;
  typedef logic [LSU_OFS_W:0]    span_t;
  typedef logic [LSU_LANES-1:0]  mask_t;

  // Indexed address: base plus sign-extended displacement, wrapping.
  function automatic word_t lsu_ea(word_t base, disp_t disp);
    word_t ext;
    ext = {{(LSU_XLEN-LSU_DISP_W){disp[LSU_DISP_W-1]}}, disp};
    return base + ext;
  endfunction

  // Number of lanes touched by one access of the given size.
  function automatic span_t lsu_span(lsu_size_e sz);
    case (sz)
      SZ_BYTE: return span_t'(1);
      SZ_HALF: return span_t'(2);
      default: return span_t'(LSU_LANES);
    endcase
  endfunction

  // Natural alignment rule; the reserved code is always refused.
  function automatic logic lsu_misaligned(lsu_size_e sz, ofs_t ofs);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return ofs[0];
      SZ_WORD: return (ofs != '0);
      default: return 1'b1;
    endcase
  endfunction

  // Shift the addressed lanes down to bit 0 and widen.
  function automatic word_t lsu_extract(word_t rdata, lsu_size_e sz, ofs_t ofs, logic uns);
    word_t sh;
    sh = rdata >> (8 * ofs);
    case (sz)
      SZ_BYTE: return {{(LSU_XLEN-8){~uns & sh[7]}}, sh[7:0]};
      SZ_HALF: return {{(LSU_XLEN-16){~uns & sh[15]}}, sh[15:0]};
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
(
  input  word_t     base,
  input  disp_t     disp,
  input  lsu_size_e size,
  output word_t     ea,
  output ofs_t      ofs,
  output logic      bad_align
);

  assign ea        = lsu_ea(base, disp);
  assign ofs       = ea[LSU_OFS_W-1:0];
  assign bad_align = lsu_misaligned(size, ofs);

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_pkg::*;
(
  input  logic      access_ok,
  input  lsu_size_e size,
  input  ofs_t      ofs,
  input  word_t     sdata,
  output mask_t     be,
  output word_t     wdata
);

  span_t span;
  assign span = lsu_span(size);

  for (genvar g = 0; g < LSU_LANES; g++) begin : g_lane
    localparam ofs_t LANE = ofs_t'(g);
    span_t diff;
    ofs_t  src;
    logic  at_or_above;

    // diff = lane - offset with a borrow bit; borrow set means lane is below.
    assign diff        = {1'b0, LANE} - {1'b0, ofs};
    assign at_or_above = ~diff[LSU_OFS_W];
    assign src         = diff[LSU_OFS_W-1:0];
    assign be[g]       = access_ok & at_or_above & (diff < span);
    assign wdata[8*g +: 8] = at_or_above ? sdata[8*src +: 8] : 8'h00;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issue,
  input  lsu_size_e size,
  input  ofs_t      ofs,
  input  logic      uns,
  input  word_t     rdata,
  output logic      rsp_valid,
  output word_t     rsp_data
);

  logic      pend_q;
  lsu_size_e size_q;
  ofs_t      ofs_q;
  logic      uns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      size_q <= SZ_BYTE;
      ofs_q  <= '0;
      uns_q  <= 1'b0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        size_q <= size;
        ofs_q  <= ofs;
        uns_q  <= uns;
      end
    end
  end

  assign rsp_valid = pend_q;
  assign rsp_data  = pend_q ? lsu_extract(rdata, size_q, ofs_q, uns_q) : '0;

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [1:0]            req_size,
  input  logic                  req_unsigned,
  input  logic [LSU_XLEN-1:0]   base,
  input  logic [LSU_DISP_W-1:0] disp,
  input  logic [LSU_XLEN-1:0]   store_data,
  output logic [LSU_XLEN-1:0]   mem_addr,
  output logic [LSU_LANES-1:0]  mem_be,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic [LSU_XLEN-1:0]   mem_wdata,
  input  logic [LSU_XLEN-1:0]   mem_rdata,
  output logic                  misalign,
  output logic                  ld_valid,
  output logic [LSU_XLEN-1:0]   ld_data
);

  lsu_size_e size_e;
  ofs_t      lane_ofs;
  logic      bad_align;
  logic      access_ok;
  logic      ld_issue;

  assign size_e = lsu_size_e'(req_size);

  lsu_agen u_agen (
    .base      (base),
    .disp      (disp),
    .size      (size_e),
    .ea        (mem_addr),
    .ofs       (lane_ofs),
    .bad_align (bad_align)
  );

  assign access_ok = req_valid & ~bad_align;
  assign misalign  = req_valid & bad_align;
  assign mem_we    = access_ok & req_store;
  assign ld_issue  = access_ok & ~req_store;
  assign mem_re    = ld_issue;

  lsu_lane_steer u_steer (
    .access_ok (access_ok),
    .size      (size_e),
    .ofs       (lane_ofs),
    .sdata     (store_data),
    .be        (mem_be),
    .wdata     (mem_wdata)
  );

  lsu_load_extract u_extract (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (ld_issue),
    .size      (size_e),
    .ofs       (lane_ofs),
    .uns       (req_unsigned),
    .rdata     (mem_rdata),
    .rsp_valid (ld_valid),
    .rsp_data  (ld_data)
  );

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        req_unsigned,
  input logic [3:0]  mem_be,
  input logic        mem_we,
  input logic        mem_re,
  input logic        misalign,
  input logic        ld_valid,
  input logic [31:0] ld_data,
  input logic        access_ok
);

  // R2
  be_byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ok && req_size == 2'b00) |-> ($countones(mem_be) == 1));

  // R2
  be_half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ok && req_size == 2'b01) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  // R2
  be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_be == 4'b0000));

  // R4
  byte_store_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |-> $onehot0(mem_be) && (mem_be != 4'b0000));

  // R5
  misalign_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_we && !mem_re && mem_be == 4'b0000));

  // R5
  misalign_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign && !req_store) |=> !ld_valid);

  // R6
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid);

  // R6
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_re));

  // R8
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(req_size) == 2'b00 && $past(req_unsigned)) |-> (ld_data[31:8] == 24'h0));

  // R9
  byte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(req_size) == 2'b00 && !$past(req_unsigned)) |-> (ld_data[31:8] == {24{ld_data[7]}}));

  // R9
  half_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(req_size) == 2'b01 && !$past(req_unsigned)) |-> (ld_data[31:16] == {16{ld_data[15]}}));

endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_store    (req_store),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .mem_be       (mem_be),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .misalign     (misalign),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data),
  .access_ok    (access_ok)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = '0, store_data = '0;
  logic [15:0] disp = '0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re, misalign, ld_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  shadow [64];
  logic [31:0] mem_model [16];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_align u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .disp(disp),
    .store_data(store_data), .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // Behavioural single-cycle memory honouring the lane enables.
  always @(posedge clk) begin
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem_model[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
    if (mem_re) mem_rdata <= mem_model[mem_addr[5:2]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop and compare load responses away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected response", ld_data, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(ld_data == e, t, ld_data, e);
      end
    end
  end

  // Driver: one request per cycle, expectations pushed to the scoreboard.
  task automatic op(input bit st, input logic [1:0] sz, input bit uns,
                    input logic [31:0] b, input logic [15:0] d,
                    input logic [31:0] sd, input string tag);
    logic [31:0] ea;
    logic [1:0]  off;
    bit          bad;
    logic [3:0]  ebe;
    int          n;
    logic [7:0]  by [4];
    logic [31:0] ev;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    base = b; disp = d; store_data = sd;
    #1;
    ea  = b + 32'($signed(d));
    off = ea[1:0];
    n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    bad = (sz == 2'b11) || (sz == 2'b01 && off[0]) || (sz == 2'b10 && off != 2'b00);
    if (bad) ebe = 4'b0000;
    else if (sz == 2'b00) ebe = 4'b0001 << off;
    else if (sz == 2'b01) ebe = (off == 2'b00) ? 4'b0011 : 4'b1100;
    else ebe = 4'b1111;
    chk(mem_addr == ea, "R1 address", mem_addr, ea);
    chk(misalign == bad, "R5 flag", 32'(misalign), 32'(bad));
    chk(mem_be == ebe, "R2 enables", 32'(mem_be), 32'(ebe));
    if (bad) chk(!mem_we && !mem_re, "R5 no access", {mem_we, mem_re}, 32'h0);
    else if (st) begin
      chk(mem_we && !mem_re, "R4 write strobe", {mem_we, mem_re}, 32'h2);
      for (int k = 0; k < n; k++) begin
        chk(mem_wdata[8*(off+k) +: 8] == sd[8*k +: 8], "R3 lane data",
            32'(mem_wdata[8*(off+k) +: 8]), 32'(sd[8*k +: 8]));
        shadow[ea[5:0] + 6'(k)] = sd[8*k +: 8];
      end
    end else begin
      for (int k = 0; k < 4; k++) by[k] = (k < n) ? shadow[ea[5:0] + 6'(k)] : 8'h00;
      if (n == 1) ev = uns ? {24'h0, by[0]} : {{24{by[0][7]}}, by[0]};
      else if (n == 2) ev = uns ? {16'h0, by[1], by[0]} : {{16{by[1][7]}}, by[1], by[0]};
      else ev = {by[3], by[2], by[1], by[0]};
      exp_q.push_back(ev);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'(i * 37 + 5);
    for (int w = 0; w < 16; w++)
      mem_model[w] = {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ld_valid == 1'b0, "R10 reset ld_valid", 32'(ld_valid), 32'h0);
    chk(mem_be == 4'h0 && !mem_we && !mem_re, "R10 reset idle", {mem_be, mem_we, mem_re}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_valid == 1'b0, "R10 after reset", 32'(ld_valid), 32'h0);

    // R7 / R3 word store then word load, lowest address in low byte
    op(1, 2'b10, 0, 32'd0, 16'd0, 32'hA1B2C3D4, "R3 word store");
    op(0, 2'b10, 0, 32'd0, 16'd0, 32'h0, "R7 word load");
    // R4 byte stores with junk in upper bytes, then neighbours intact
    op(1, 2'b00, 0, 32'd4, 16'd1, 32'hFFFFFF80, "R4 byte store");
    op(1, 2'b00, 0, 32'd4, 16'd2, 32'h12345677, "R4 byte store");
    op(0, 2'b10, 0, 32'd4, 16'd0, 32'h0, "R4 neighbours word");
    // R8 / R9 byte loads at all offsets, both extensions
    for (int o = 0; o < 4; o++) begin
      op(0, 2'b00, 1, 32'd4, 16'(o), 32'h0, "R8 byte zero-extend");
      op(0, 2'b00, 0, 32'd4, 16'(o), 32'h0, "R9 byte sign-extend");
    end
    // R2 halfword stores at offsets 0 and 2, loads both ways
    op(1, 2'b01, 0, 32'd8, 16'd0, 32'hDEAD8001, "R3 half store lo");
    op(1, 2'b01, 0, 32'd8, 16'd2, 32'hBEEF7FFE, "R3 half store hi");
    op(0, 2'b01, 1, 32'd8, 16'd0, 32'h0, "R8 half zero-extend");
    op(0, 2'b01, 0, 32'd8, 16'd0, 32'h0, "R9 half sign-extend");
    op(0, 2'b01, 0, 32'd8, 16'd2, 32'h0, "R9 half positive");
    op(0, 2'b10, 0, 32'd8, 16'd0, 32'h0, "R7 word after halves");
    // R1 negative displacement and wrap-around
    op(0, 2'b10, 0, 32'd40, 16'hFFF8, 32'h0, "R1 negative disp load");
    op(0, 2'b00, 0, 32'hFFFFFFF0, 16'h0014, 32'h0, "R1 wrap load");
    idle();
    // R5 misaligned and reserved: refused, memory untouched
    op(1, 2'b01, 0, 32'd12, 16'd1, 32'h11111111, "R5 half odd store");
    op(1, 2'b10, 0, 32'd12, 16'd2, 32'h22222222, "R5 word off2 store");
    op(0, 2'b10, 0, 32'd12, 16'd3, 32'h0, "R5 word off3 load");
    op(1, 2'b11, 0, 32'd12, 16'd0, 32'h33333333, "R5 reserved store");
    op(0, 2'b11, 0, 32'd12, 16'd0, 32'h0, "R5 reserved load");
    idle();
    @(negedge clk);
    chk(ld_valid == 1'b0, "R5 no response", 32'(ld_valid), 32'h0);
    op(0, 2'b10, 0, 32'd12, 16'd0, 32'h0, "R5 memory unchanged");
    // R6 back-to-back loads
    op(0, 2'b00, 1, 32'd0, 16'd3, 32'h0, "R6 back-to-back a");
    op(0, 2'b01, 1, 32'd0, 16'd2, 32'h0, "R6 back-to-back b");
    idle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog expired actual=%0d expected=0", exp_q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule